// File: doc/BRIEF.md
# Synchronous Flash Command Sequencer

This block turns single host requests into short command triplets for a synchronous flash device. The device sits on an SDRAM-style command bus. A host write becomes a program sequence. The sequencer first loads the device command register with the program-setup opcode, then opens the target row, then issues a write command that carries the column and the data. A host read becomes a status poll. It loads the read-status opcode, opens the row, issues a read, and after the CAS latency captures the device's status byte from the low eight data lines.

The host holds a request until the block accepts it, which happens on any clock edge where the block is idle. While a triplet is in flight, `busy` is high and further requests are ignored. The end of each sequence is marked by a one-cycle `done` pulse, and on a status poll the captured byte is presented with that pulse. The CAS latency and the activate-to-access delay are set by parameters. The host address is split into bank, row and column fields whose widths are also parameters.

Top module: `sflash_seq`

## Requirements
- R1: After reset, and whenever no sequence runs, `busy`=0, `done`=0, `sf_cs_n`=1, {`sf_ras_n`,`sf_cas_n`,`sf_we_n`}=3'b111 and `sf_dq_oe`=0.
- R2: A request seen with `req_valid`=1 at an idle clock edge is accepted. In the next cycle the block drives command-register load {ras,cas,we}=3'b000 with `sf_cs_n`=0. In that cycle `sf_a[7:0]` is 0x40 for a write and 0x70 for a read. `sf_a` bits above bit 7 carry the same bits of the row field, and `sf_ba` carries the bank field. The host address layout is {bank, row, column}, with the column in the least significant bits.
- R3: The cycle after the command-register load drives Active (3'b011), with `sf_a` equal to the row field and `sf_ba` equal to the bank.
- R4: Between Active and the access command the block issues exactly TRCD-1 cycles of NOP (3'b111, `sf_cs_n`=0). The access command therefore comes TRCD cycles after Active.
- R5: For a write, the access cycle drives Write (3'b100), `sf_a` = the column zero-extended, `sf_ba` = the bank, and `sf_dq_out` = the request's write data with `sf_dq_oe`=1.
- R6: For a read, the access cycle drives Read (3'b101) with `sf_a` = the column zero-extended and `sf_ba` = the bank.
- R7: For a read, `status` takes `sf_stat_in` as sampled at the clock edge CAS_LAT cycles after the edge that ends the Read cycle. It is presented in the cycle of the `done` pulse and held until the next read completes.
- R8: `done` is high for exactly one cycle. For a write, this is the cycle after the Write cycle. For a read, it is the cycle after the CAS_LAT NOP cycles that follow Read. `busy` is high from the command-register load through the cycle before `done`, and low while `done` is high.
- R9: Requests presented while `busy`=1 are ignored and do not change the address, data or kind of the sequence in flight.
- R10: The block never issues Burst Terminate (3'b110 with `sf_cs_n`=0).
- R11: `sf_dq_oe` is 1 only in the Write cycle. Otherwise the data lines are released and `sf_dq_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = program, 0 = status read |
| req_addr | input | BANK_W+ROW_W+COL_W | Host address {bank,row,col} |
| req_wdata | input | DATA_W | Data to program |
| busy | output | 1 | Sequence in flight |
| done | output | 1 | One-cycle end-of-sequence pulse |
| status | output | 8 | Last captured status byte |
| sf_cs_n | output | 1 | Chip select, active low |
| sf_ras_n | output | 1 | Row strobe, active low |
| sf_cas_n | output | 1 | Column strobe, active low |
| sf_we_n | output | 1 | Write enable, active low |
| sf_ba | output | BANK_W | Bank address |
| sf_a | output | ROW_W | Multiplexed address bus |
| sf_dq_out | output | DATA_W | Data driven toward the device |
| sf_dq_oe | output | 1 | Data output enable |
| sf_stat_in | input | 8 | Low eight data lines from the device |

## Verification
The bench builds the block with CAS_LAT=3 and TRCD=3. With these values the access command is preceded by two NOP cycles and the status capture by three NOP cycles, so an off-by-one in either counter shifts a command or a captured byte. The device model drives valid status only in the single cycle the latency allows, and a marker value in every other cycle. A capture made one edge early or late therefore reads the marker. A 12-bit row makes the upper address lines in the command-register load carry real row bits, distinct from the opcode byte.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2,
  parameter int TRCD    = 2,
  localparam int HADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic [7:0]         status,
  output logic               sf_cs_n,
  output logic               sf_ras_n,
  output logic               sf_cas_n,
  output logic               sf_we_n,
  output logic [BANK_W-1:0]  sf_ba,
  output logic [ROW_W-1:0]   sf_a,
  output logic [DATA_W-1:0]  sf_dq_out,
  output logic               sf_dq_oe,
  input  logic [7:0]         sf_stat_in
);

  localparam logic [7:0] OP_PROG = 8'h40;
  localparam logic [7:0] OP_STAT = 8'h70;
  localparam int CNT_W = $clog2(TRCD + CAS_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_LCR, S_ACT, S_RCD, S_ACC, S_LAT} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              op_wr;
  logic [BANK_W-1:0] op_bank;
  logic [ROW_W-1:0]  op_row;
  logic [COL_W-1:0]  op_col;
  logic [DATA_W-1:0] op_data;
  logic [2:0]        cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      status  <= '0;
      op_wr   <= 1'b0;
      op_bank <= '0;
      op_row  <= '0;
      op_col  <= '0;
      op_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          op_wr   <= req_write;
          {op_bank, op_row, op_col} <= req_addr;
          op_data <= req_wdata;
          st      <= S_LCR;
        end
        S_LCR: st <= S_ACT;
        S_ACT: if (TRCD > 1) begin
          cnt <= CNT_W'(TRCD - 2);
          st  <= S_RCD;
        end else begin
          st  <= S_ACC;
        end
        S_RCD: if (cnt == '0) st <= S_ACC;
               else cnt <= cnt - 1'b1;
        S_ACC: if (op_wr) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          cnt <= CNT_W'(CAS_LAT - 1);
          st  <= S_LAT;
        end
        S_LAT: if (cnt == '0) begin
          status <= sf_stat_in;
          done   <= 1'b1;
          st     <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_LCR:   cmd = 3'b000;
      S_ACT:   cmd = 3'b011;
      S_ACC:   cmd = op_wr ? 3'b100 : 3'b101;
      default: cmd = 3'b111;
    endcase
  end

  always_comb begin
    unique case (st)
      S_LCR:   sf_a = {op_row[ROW_W-1:8], op_wr ? OP_PROG : OP_STAT};
      S_ACT:   sf_a = op_row;
      S_ACC:   sf_a = ROW_W'(op_col);
      default: sf_a = '0;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign sf_cs_n   = !busy;
  assign {sf_ras_n, sf_cas_n, sf_we_n} = cmd;
  assign sf_ba     = busy ? op_bank : '0;
  assign sf_dq_oe  = (st == S_ACC) && op_wr;
  assign sf_dq_out = sf_dq_oe ? op_data : '0;

endmodule

module sflash_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [AW-1:0] a,
  input logic          dq_oe
);
  logic [2:0] cmd;
  assign cmd = {ras_n, cas_n, we_n};

  // R10
  no_burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> cmd != 3'b110);

  // R11
  oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cs_n && cmd == 3'b100));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  start_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd == 3'b000 && (a[7:0] == 8'h40 || a[7:0] == 8'h70)));

  // R3
  lcr_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cmd == 3'b000) |=> (!cs_n && cmd == 3'b011));

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && cmd == 3'b111 && !dq_oe));
endmodule

bind sflash_seq sflash_seq_chk #(.AW(ROW_W)) u_sflash_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cs_n(sf_cs_n),
  .ras_n(sf_ras_n), .cas_n(sf_cas_n), .we_n(sf_we_n), .a(sf_a), .dq_oe(sf_dq_oe)
);

// File: tb/test_sflash_seq.sv
module test_sflash_seq;
  localparam int BW = 2, RW = 12, CW = 8, DW = 16, CL = 3, TR = 3;
  localparam int HW = BW + RW + CW;
  localparam int NV = 6;
  localparam int VW = 1 + HW + DW + 8;

  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'd1, 12'hABC, 8'h5A, 16'h1234, 8'h00},
    {1'b0, 2'd2, 12'h3F0, 8'hC3, 16'h0000, 8'h80},
    {1'b1, 2'd3, 12'hFFF, 8'hFF, 16'hFFFF, 8'h00},
    {1'b0, 2'd0, 12'h000, 8'h00, 16'h0000, 8'h01},
    {1'b0, 2'd3, 12'h912, 8'h7E, 16'h0000, 8'hFE},
    {1'b1, 2'd0, 12'h001, 8'h80, 16'hA55A, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [HW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [7:0] status, stat_in;
  logic [BW-1:0] ba;
  logic [RW-1:0] a;
  logic [DW-1:0] dq_out;
  logic [7:0] dev_stat = 8'h00;
  logic [CL-1:0] pipe = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sflash_seq #(.BANK_W(BW), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
               .CAS_LAT(CL), .TRCD(TR)) i_sflash_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .status(status), .sf_cs_n(cs_n), .sf_ras_n(ras_n), .sf_cas_n(cas_n),
    .sf_we_n(we_n), .sf_ba(ba), .sf_a(a), .sf_dq_out(dq_out),
    .sf_dq_oe(dq_oe), .sf_stat_in(stat_in));

  always @(posedge clk) pipe <= {pipe[CL-2:0], (!cs_n && {ras_n, cas_n, we_n} == 3'b101)};
  assign stat_in = pipe[CL-1] ? dev_stat : 8'hE7;

  task automatic chk(input string req, input bit ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", req, got, exp);
    end
  endtask

  function automatic string pins();
    return $sformatf("cs=%0b cmd=%03b ba=%0d a=%h oe=%0b dq=%h busy=%0b done=%0b",
                     cs_n, {ras_n, cas_n, we_n}, ba, a, dq_oe, dq_out, busy, done);
  endfunction

  task automatic expect_pins(input string req, input bit e_cs, input logic [2:0] e_cmd,
                             input logic [BW-1:0] e_ba, input logic [RW-1:0] e_a,
                             input bit e_oe, input logic [DW-1:0] e_dq,
                             input bit e_busy, input bit e_done);
    bit ok;
    ok = cs_n == e_cs && {ras_n, cas_n, we_n} == e_cmd && dq_oe == e_oe &&
         dq_out == e_dq && busy == e_busy && done == e_done;
    if (!e_cs) ok = ok && ba == e_ba && (e_cmd == 3'b111 || a == e_a);
    chk(req, ok, pins(),
        $sformatf("cs=%0b cmd=%03b ba=%0d a=%h oe=%0b dq=%h busy=%0b done=%0b",
                  e_cs, e_cmd, e_ba, e_a, e_oe, e_dq, e_busy, e_done));
  endtask

  task automatic run_op(input logic [VW-1:0] v, input bit hold);
    bit wr;
    logic [BW-1:0] bk;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    logic [DW-1:0] wd;
    logic [7:0] st;
    {wr, bk, row, col, wd, st} = v;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = {bk, row, col}; req_wdata = wd;
    dev_stat = st;
    @(negedge clk);
    if (hold) begin
      // R9: a competing request held during the sequence
      req_write = !wr; req_addr = ~req_addr; req_wdata = ~wd;
    end else req_valid = 0;
    // R2
    expect_pins("R2 command-register load", 0, 3'b000, bk,
                {row[RW-1:8], wr ? 8'h40 : 8'h70}, 0, '0, 1, 0);
    @(negedge clk);
    // R3
    expect_pins("R3 activate", 0, 3'b011, bk, row, 0, '0, 1, 0);
    for (int k = 0; k < TR - 1; k++) begin
      @(negedge clk);
      // R4
      expect_pins("R4 activate-to-access NOP", 0, 3'b111, bk, '0, 0, '0, 1, 0);
    end
    @(negedge clk);
    if (wr) begin
      // R5 R11
      expect_pins("R5 write command", 0, 3'b100, bk, RW'(col), 1, wd, 1, 0);
      req_valid = 0;
      @(negedge clk);
      // R8
      expect_pins("R8 write done", 1, 3'b111, '0, '0, 0, '0, 0, 1);
    end else begin
      // R6
      expect_pins("R6 read command", 0, 3'b101, bk, RW'(col), 0, '0, 1, 0);
      for (int k = 0; k < CL; k++) begin
        @(negedge clk);
        // R7
        expect_pins("R7 CAS latency NOP", 0, 3'b111, bk, '0, 0, '0, 1, 0);
      end
      req_valid = 0;
      @(negedge clk);
      // R8
      expect_pins("R8 read done", 1, 3'b111, '0, '0, 0, '0, 0, 1);
      // R7
      chk("R7 status byte", status == st, $sformatf("%h", status), $sformatf("%h", st));
    end
    @(negedge clk);
    // R8 R1
    expect_pins("R8 done single pulse / R1 idle", 1, 3'b111, '0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_pins("R1 reset state", 1, 3'b111, '0, '0, 0, '0, 0, 0);
    chk("R1 reset status", status == 8'h00, $sformatf("%h", status), "00");
    rst_n = 1;
    @(negedge clk);
    expect_pins("R1 idle after reset", 1, 3'b111, '0, '0, 0, '0, 0, 0);

    for (int i = 0; i < NV; i++) run_op(VEC[i], 0);

    // R9: busy ignores requests; check nothing new starts afterwards
    run_op(VEC[0], 1);
    @(negedge clk);
    expect_pins("R9 no queued sequence", 1, 3'b111, '0, '0, 0, '0, 0, 0);

    // R9 on read, R7 status held across a write
    run_op(VEC[1], 1);
    run_op(VEC[2], 0);
    chk("R7 status held", status == 8'h80, $sformatf("%h", status), "80");

    // R1: reset mid-sequence returns to idle
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = '1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    expect_pins("R1 reset mid-sequence", 1, 3'b111, '0, '0, 0, '0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    expect_pins("R1 stays idle after reset", 1, 3'b111, '0, '0, 0, '0, 0, 0);
    run_op(VEC[4], 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule